// File: doc/BRIEF.md
# Software Key Register Bank

This block holds two eight-word keys behind a simple register read/write port: a symmetric key that feeds a key consumer through a parallel output, and an asymmetric key that software may fetch only once per word. Symmetric key words have to arrive in strict ascending order. A write out of that order invalidates the whole key, and the key then stays zero until a new sequence starts at word 0.

Words can also be loaded from a random-number source through a strobe, an index and a data input. A control bit chooses whether a random word overwrites the stored word or is XOR-mixed into it. That control bit can be frozen by a sticky lock. Two further sticky bits stop software from reading back either key. All sticky bits stay set until reset.

Top module: `swkey_bank`

## Requirements
- R1: After reset every register reads 0, `skey_valid_o` is 0 and `skey_o` is all zeros.
- R2: Writing symmetric words 0..7 at byte offsets 0x00..0x1C in ascending order sets `skey_valid_o` to 1. `skey_o` then carries word i in bits [32i+31:32i]. A read of a symmetric word returns its stored value.
- R3: A write to a symmetric word whose index is neither 0 nor the next expected index puts the bank in error. In error, `skey_valid_o` is 0, `skey_o` is zero and symmetric reads return 0. A later write to word 0 followed by words 1..7 in order restores a valid key.
- R4: A read of an asymmetric word (offsets 0x20..0x3C) returns its value the first time and 0 on every later read. Rewriting the word makes it readable once more.
- R5: A random load (`rnd_valid_i`, index `rnd_idx_i`) changes that symmetric word to `rnd_data_i` when bit 0 of register 0x48 is 0, and to the stored word XOR `rnd_data_i` when that bit is 1. Random loads do not change the write-order state.
- R6: Bit 16 of register 0x48 is a lock. A write of 1 sets it and it stays set until reset. While it is set, writes to bit 0 of 0x48 are ignored. A write that sets the lock still updates bit 0 in that same write. Register 0x48 reads back the lock in bit 16 and the mode bit in bit 0.
- R7: Register 0x4C bit 0 blocks symmetric readout and bit 16 blocks asymmetric readout. A blocked key reads as 0. Both bits are sticky: writes of 0 are ignored. Blocking readout does not affect `skey_o`.
- R8: Read data appears on `rdata_o` with `rvalid_o` high exactly one cycle after the read request. Offsets 0x40, 0x44, anything above 0x4C and misaligned byte addresses read as 0, and writes to them have no effect.
- R9: When a bus write and a random load target the same symmetric word in the same cycle, the bus write value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rnd_valid_i | input | 1 | Random word strobe |
| rnd_idx_i | input | log2(KW) | Symmetric word targeted by the random word |
| rnd_data_i | input | DW | Random word |
| skey_o | output | KW*DW | Effective symmetric key, zero unless valid |
| skey_valid_o | output | 1 | Symmetric key fully written in order, no error |

## Verification
The hardest case to reach is a bus write and a random load hitting the same word in the same cycle, because the two sources normally arrive from independent agents. The bench drives both in one cycle and then reads the word back. The error state is reached by restarting a sequence and then skipping ahead. Its recovery is checked with a complete fresh sequence. The once-only read is exercised by reading a word twice, rewriting it and reading it again. A word that was never read is then used to show that the asymmetric block applies even to a word not yet consumed.

// File: rtl/swkey_pkg.sv
package swkey_pkg;
  localparam int MIX_BIT      = 0;
  localparam int LOCK_BIT     = 16;
  localparam int BLK_SYM_BIT  = 0;
  localparam int BLK_ASYM_BIT = 16;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_SYM,
    RG_ASYM,
    RG_RNG,
    RG_RDC
  } region_e;
endpackage

// File: rtl/swkey_order_trk.sv
module swkey_order_trk #(
  parameter int KW = 8,
  localparam int IW = $clog2(KW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  output logic          err_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(KW - 1);

  logic [IW-1:0] next_q;
  logic          err_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_i) begin
      if (idx_i == '0) begin
        // word 0 always restarts the sequence
        err_q  <= 1'b0;
        done_q <= 1'b0;
        next_q <= IW'(1);
      end else if (!err_q && !done_q && idx_i == next_q) begin
        done_q <= (idx_i == LAST);
        next_q <= (idx_i == LAST) ? '0 : next_q + IW'(1);
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign err_o  = err_q;
  assign done_o = done_q;
endmodule

// File: rtl/swkey_sym_bank.sv
module swkey_sym_bank #(
  parameter int KW = 8,
  parameter int DW = 32,
  localparam int IW = $clog2(KW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rnd_valid_i,
  input  logic [IW-1:0]    rnd_idx_i,
  input  logic [DW-1:0]    rnd_data_i,
  input  logic             mix_i,
  output logic [KW*DW-1:0] words_o
);
  for (genvar g = 0; g < KW; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          bus_hit, rnd_hit;
    assign bus_hit = wr_i && (wr_idx_i == IW'(g));
    assign rnd_hit = rnd_valid_i && (rnd_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (bus_hit) word_q <= wdata_i;
      else if (rnd_hit) word_q <= mix_i ? (word_q ^ rnd_data_i) : rnd_data_i;
    end

    assign words_o[g*DW +: DW] = word_q;
  end
endmodule

// File: rtl/swkey_asym_bank.sv
module swkey_asym_bank #(
  parameter int KW = 8,
  parameter int DW = 32,
  localparam int IW = $clog2(KW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic          blk_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] word_q [KW];
  logic [KW-1:0] used_q;

  for (genvar g = 0; g < KW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
        used_q[g] <= 1'b0;
      end else if (wr_i && wr_idx_i == IW'(g)) begin
        word_q[g] <= wdata_i;
        used_q[g] <= 1'b0;
      end else if (rd_i && !blk_i && rd_idx_i == IW'(g)) begin
        used_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o = (blk_i || used_q[rd_idx_i]) ? '0 : word_q[rd_idx_i];
endmodule

// File: rtl/swkey_ctl.sv
module swkey_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rng_wr_i,
  input  logic rdc_wr_i,
  input  logic bit_lo_i,
  input  logic bit_hi_i,
  output logic mix_o,
  output logic lock_o,
  output logic blk_sym_o,
  output logic blk_asym_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mix_o      <= 1'b0;
      lock_o     <= 1'b0;
      blk_sym_o  <= 1'b0;
      blk_asym_o <= 1'b0;
    end else begin
      if (rng_wr_i) begin
        if (!lock_o)  mix_o  <= bit_lo_i;
        if (bit_hi_i) lock_o <= 1'b1;
      end
      if (rdc_wr_i) begin
        if (bit_lo_i) blk_sym_o  <= 1'b1;
        if (bit_hi_i) blk_asym_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swkey_bank.sv
module swkey_bank
  import swkey_pkg::*;
#(
  parameter int KW     = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 7,
  localparam int IW    = $clog2(KW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  input  logic             rnd_valid_i,
  input  logic [IW-1:0]    rnd_idx_i,
  input  logic [DW-1:0]    rnd_data_i,
  output logic [KW*DW-1:0] skey_o,
  output logic             skey_valid_o
);
  localparam int WAW = ADDR_W - 2;
  localparam logic [WAW-1:0] ASYM_LO = WAW'(KW);
  localparam logic [WAW-1:0] ASYM_HI = WAW'(2 * KW);
  localparam logic [WAW-1:0] RNG_W   = WAW'(2 * KW + 2);
  localparam logic [WAW-1:0] RDC_W   = WAW'(2 * KW + 3);

  logic [WAW-1:0] widx, asym_off;
  logic [IW-1:0]  sym_idx, asym_idx;
  region_e        region;
  logic           wr, rd;

  assign widx     = addr_i[ADDR_W-1:2];
  assign asym_off = widx - ASYM_LO;
  assign sym_idx  = widx[IW-1:0];
  assign asym_idx = asym_off[IW-1:0];
  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;

  always_comb begin
    region = RG_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (widx < ASYM_LO)                         region = RG_SYM;
      else if (widx < ASYM_HI)                    region = RG_ASYM;
      else if (widx == RNG_W)                     region = RG_RNG;
      else if (widx == RDC_W)                     region = RG_RDC;
    end
  end

  logic mix, rng_lock, blk_sym, blk_asym;
  logic seq_err, seq_done;
  logic [KW*DW-1:0] sym_words;
  logic [DW-1:0]    asym_rdata;

  swkey_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rng_wr_i   (wr && region == RG_RNG),
    .rdc_wr_i   (wr && region == RG_RDC),
    .bit_lo_i   (wdata_i[MIX_BIT]),
    .bit_hi_i   (wdata_i[LOCK_BIT]),
    .mix_o      (mix),
    .lock_o     (rng_lock),
    .blk_sym_o  (blk_sym),
    .blk_asym_o (blk_asym)
  );

  swkey_order_trk #(.KW(KW)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr && region == RG_SYM),
    .idx_i  (sym_idx),
    .err_o  (seq_err),
    .done_o (seq_done)
  );

  swkey_sym_bank #(.KW(KW), .DW(DW)) u_sym (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr && region == RG_SYM),
    .wr_idx_i    (sym_idx),
    .wdata_i     (wdata_i),
    .rnd_valid_i (rnd_valid_i),
    .rnd_idx_i   (rnd_idx_i),
    .rnd_data_i  (rnd_data_i),
    .mix_i       (mix),
    .words_o     (sym_words)
  );

  swkey_asym_bank #(.KW(KW), .DW(DW)) u_asym (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && region == RG_ASYM),
    .wr_idx_i  (asym_idx),
    .wdata_i   (wdata_i),
    .rd_i      (rd && region == RG_ASYM),
    .rd_idx_i  (asym_idx),
    .blk_i     (blk_asym),
    .rd_data_o (asym_rdata)
  );

  logic [DW-1:0] rd_mux, rdata_q;
  logic          rvalid_q;

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_SYM:  rd_mux = (blk_sym || seq_err) ? '0 : sym_words[sym_idx*DW +: DW];
      RG_ASYM: rd_mux = asym_rdata;
      RG_RNG: begin
        rd_mux[MIX_BIT]  = mix;
        rd_mux[LOCK_BIT] = rng_lock;
      end
      RG_RDC: begin
        rd_mux[BLK_SYM_BIT]  = blk_sym;
        rd_mux[BLK_ASYM_BIT] = blk_asym;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign rdata_o      = rdata_q;
  assign rvalid_o     = rvalid_q;
  assign skey_valid_o = seq_done && !seq_err;
  assign skey_o       = skey_valid_o ? sym_words : '0;
endmodule

// File: rtl/swkey_bank_chk.sv
module swkey_bank_chk #(
  parameter int KW     = 8,
  parameter int DW     = 32,
  parameter int ADDR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]    rdata_o,
  input logic             rvalid_o,
  input logic [KW*DW-1:0] skey_o,
  input logic             skey_valid_o,
  input logic             mix,
  input logic             rng_lock,
  input logic             blk_sym,
  input logic             blk_asym
);
  logic sym_rd;
  assign sym_rd = req_i && !we_i && addr_i[1:0] == 2'b00 &&
                  (int'(addr_i[ADDR_W-1:2]) < KW);

  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);                              // R8
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);                            // R8
  AST_INVALID_KEY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skey_valid_o |-> (skey_o == '0));                           // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_lock |=> rng_lock);                                      // R6
  AST_MIX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_lock |=> $stable(mix));                                  // R6
  AST_BLK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_sym || blk_asym) |=> (blk_sym >= $past(blk_sym) && blk_asym >= $past(blk_asym))); // R7
  AST_SYM_BLOCKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_rd && blk_sym) |=> (rdata_o == '0));                    // R7
endmodule

bind swkey_bank swkey_bank_chk #(.KW(KW), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .rvalid_o     (rvalid_o),
  .skey_o       (skey_o),
  .skey_valid_o (skey_valid_o),
  .mix          (mix),
  .rng_lock     (rng_lock),
  .blk_sym      (blk_sym),
  .blk_asym     (blk_asym)
);

// File: tb/swkey_bank_bench.sv
module swkey_bank_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [6:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         rvalid;
  logic         rnd_valid = 1'b0;
  logic [2:0]   rnd_idx = '0;
  logic [31:0]  rnd_data = '0;
  logic [255:0] skey;
  logic         skey_valid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mk [8];

  always #10 clk = ~clk;

  swkey_bank u_swkey_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .rnd_valid_i(rnd_valid), .rnd_idx_i(rnd_idx), .rnd_data_i(rnd_data),
    .skey_o(skey), .skey_valid_o(skey_valid)
  );

  function automatic logic [31:0] kw(int i);
    return 32'hA5A5_0000 ^ (32'h0101_0101 * i);
  endfunction

  function automatic logic [255:0] model_key();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = mk[i];
    return k;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rnd_load(logic [2:0] i, logic [31:0] d);
    @(negedge clk);
    rnd_valid = 1'b1; rnd_idx = i; rnd_data = d;
    @(negedge clk);
    rnd_valid = 1'b0;
  endtask

  // monitor: read data one cycle after request, compared in order
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected rvalid act=%h exp=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mk[i] = kw(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 valid", {255'd0, skey_valid}, 256'd0);
    chk("R1 key", skey, 256'd0);
    bus_rd(7'h00, 32'h0, "R1 sym");
    bus_rd(7'h20, 32'h0, "R1 asym");
    bus_rd(7'h48, 32'h0, "R1 rng");
    bus_rd(7'h4C, 32'h0, "R1 rdc");

    // R2 in-order load
    for (int i = 0; i < 8; i++) bus_wr(7'(i*4), kw(i));
    chk("R2 valid", {255'd0, skey_valid}, 256'd1);
    chk("R2 key", skey, model_key());
    bus_rd(7'h0C, kw(3), "R2 readback");

    // R4 read-once asymmetric words
    for (int j = 0; j < 8; j++) bus_wr(7'(32 + j*4), 32'hC0DE_0000 | 32'(j));
    bus_rd(7'h24, 32'hC0DE_0001, "R4 first");
    bus_rd(7'h24, 32'h0, "R4 second");
    bus_wr(7'h24, 32'h5555_AAAA);
    bus_rd(7'h24, 32'h5555_AAAA, "R4 rewrite");
    bus_rd(7'h28, 32'hC0DE_0002, "R4 other");

    // R5 random replace then XOR mix
    rnd_load(3'd2, 32'hDEAD_BEEF);
    mk[2] = 32'hDEAD_BEEF;
    chk("R5 replace", skey, model_key());
    chk("R5 order kept", {255'd0, skey_valid}, 256'd1);
    bus_wr(7'h48, 32'h1);
    bus_rd(7'h48, 32'h1, "R6 mix readback");
    rnd_load(3'd2, 32'h0F0F_1234);
    mk[2] = mk[2] ^ 32'h0F0F_1234;
    chk("R5 xor", skey, model_key());

    // R8 unmapped and misaligned
    bus_wr(7'h40, 32'hFFFF_FFFF);
    bus_rd(7'h40, 32'h0, "R8 0x40");
    bus_rd(7'h44, 32'h0, "R8 0x44");
    bus_rd(7'h7C, 32'h0, "R8 0x7C");
    bus_rd(7'h0D, 32'h0, "R8 misaligned");
    chk("R8 key untouched", skey, model_key());

    // R9 bus write and random load on the same word
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 7'h00; wdata = 32'h0BAD_F00D;
    rnd_valid = 1'b1; rnd_idx = 3'd0; rnd_data = 32'h1111_1111;
    @(negedge clk);
    req = 1'b0; we = 1'b0; rnd_valid = 1'b0;
    mk[0] = 32'h0BAD_F00D;
    bus_rd(7'h00, 32'h0BAD_F00D, "R9 bus wins");
    chk("R3 restart invalid", {255'd0, skey_valid}, 256'd0);

    // R3 out-of-order write then recovery
    bus_wr(7'h0C, 32'h1234_5678);
    chk("R3 err valid", {255'd0, skey_valid}, 256'd0);
    chk("R3 err key", skey, 256'd0);
    bus_rd(7'h00, 32'h0, "R3 err read");
    for (int i = 0; i < 8; i++) begin
      mk[i] = kw(i) ^ 32'hFFFF_0000;
      bus_wr(7'(i*4), mk[i]);
    end
    chk("R3 recover valid", {255'd0, skey_valid}, 256'd1);
    chk("R3 recover key", skey, model_key());

    // R6 lock
    bus_wr(7'h48, 32'h0001_0000);
    bus_rd(7'h48, 32'h0001_0000, "R6 lock set");
    bus_wr(7'h48, 32'h1);
    bus_rd(7'h48, 32'h0001_0000, "R6 mix ignored");
    bus_wr(7'h48, 32'h0);
    bus_rd(7'h48, 32'h0001_0000, "R6 sticky");
    rnd_load(3'd4, 32'h7777_0000);
    mk[4] = 32'h7777_0000;
    chk("R6 replace mode held", skey, model_key());

    // R7 read blocking
    bus_wr(7'h4C, 32'h1);
    bus_rd(7'h04, 32'h0, "R7 sym blocked");
    chk("R7 key still out", skey, model_key());
    bus_wr(7'h4C, 32'h0);
    bus_rd(7'h4C, 32'h1, "R7 sym sticky");
    bus_wr(7'h4C, 32'h0001_0000);
    bus_rd(7'h2C, 32'h0, "R7 asym blocked");
    bus_rd(7'h4C, 32'h0001_0001, "R7 both");

    repeat (3) @(negedge clk);
    chk("R8 all reads returned", 256'(exp_q.size()), 256'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule